// File: doc/BRIEF.md
# UART FIFO Control with Trigger Interrupts

This block is the FIFO control stage of a UART. A host writes an 8-bit control word that switches the transmit and receive FIFOs on or off, clears either FIFO's pointers and level, selects a trigger level, and arms a wake-up enable. Both FIFOs hold bytes and have push and pop ports. Each FIFO reports its fill level. The block raises a receive interrupt when the receive FIFO fills to the trigger. It raises a transmit interrupt when the transmit FIFO drains below the trigger, or when it drains to empty.

An enhanced-features input gates the wake-up enable bit and the transmit trigger field. The two directions share a single trigger table select. Each write that programs a trigger field updates that select, and the new level then applies to both the transmit and receive comparisons.

Top module: `uart_fifo_ctrl`

## Requirements
- R1: After reset, fifo_en_o, wake_en_o, both levels, both interrupts and rx_overrun_o are 0, and trig_level_o is 8.
- R2: A control write with bit 0 clear sets fifo_en_o to 0. It leaves the trigger select, the wake enable and both FIFO contents unchanged.
- R3: A control write with bit 0 set and bit 1 set empties the receive FIFO and clears rx_overrun_o at that clock edge. With bit 0 set and bit 2 set, the write empties the transmit FIFO and drops tx_irq_o. In both cases the other FIFO is left untouched.
- R4: Bit 3 (the wake enable) is loaded only when ext_en_i is 1 and bit 0 is 1.
- R5: A write with bit 0 set loads the trigger select from bits 5:4 when ext_en_i is 1, and otherwise from bits 7:6. Select codes 0, 1, 2 and 3 give trigger levels 8, 16, 56 and 60 on trig_level_o.
- R6: rx_irq_o is 1 exactly when the FIFOs are enabled and rx_level_o is at or above trig_level_o.
- R7: tx_irq_o sets one cycle after tx_level_o falls from at or above the trigger to below it. It clears one cycle after tx_level_o reaches the trigger.
- R8: tx_irq_o sets one cycle after tx_level_o drops from nonzero to 0, even if the level never reached the trigger.
- R9: Each FIFO returns bytes in push order and holds at most 128 bytes. A push to a full FIFO and a pop from an empty FIFO change neither the level nor the data.
- R10: A receive push while the receive FIFO is full sets rx_overrun_o, and it stays set until a receive FIFO reset.
- R11: While fifo_en_o is 0, pushes and pops are ignored and both interrupts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_wdata_i | input | 8 | Control word |
| ext_en_i | input | 1 | Enhanced-features enable |
| tx_push_i | input | 1 | Transmit FIFO push |
| tx_data_i | input | 8 | Transmit push data |
| tx_pop_i | input | 1 | Transmit FIFO pop |
| tx_data_o | output | 8 | Transmit FIFO head byte |
| tx_level_o | output | 8 | Transmit FIFO fill level |
| rx_push_i | input | 1 | Receive FIFO push |
| rx_data_i | input | 8 | Receive push data |
| rx_pop_i | input | 1 | Receive FIFO pop |
| rx_data_o | output | 8 | Receive FIFO head byte |
| rx_level_o | output | 8 | Receive FIFO fill level |
| fifo_en_o | output | 1 | FIFOs enabled |
| wake_en_o | output | 1 | Wake-up interrupt enable |
| trig_level_o | output | 8 | Active shared trigger level |
| tx_irq_o | output | 1 | Transmit trigger interrupt |
| rx_irq_o | output | 1 | Receive trigger interrupt |
| rx_overrun_o | output | 1 | Sticky receive overrun flag |

## Verification
The following results are visible after the clock edge that accepts the write, push or pop: the control fields, the FIFO levels, the head bytes and the overrun flag. rx_irq_o follows the registered receive level in the same cycle. tx_irq_o comes from a tracker that compares the previous and current transmit level, so it changes one edge later. The bench drives on falling edges and samples on the next falling edge. For transmit-interrupt checks it first confirms the old value and then adds one idle cycle before checking the new value.

// File: rtl/uart_fcr_pkg.sv
package uart_fcr_pkg;
  localparam int unsigned CTRL_W   = 8;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned RXCLR_BIT = 1;
  localparam int unsigned TXCLR_BIT = 2;
  localparam int unsigned WAKE_BIT = 3;
  localparam int unsigned TXSEL_LO = 4;
  localparam int unsigned RXSEL_LO = 6;

  typedef logic [1:0] trig_sel_t;

  function automatic logic [7:0] trig_of(input trig_sel_t sel);
    case (sel)
      2'd0:    trig_of = 8'd8;
      2'd1:    trig_of = 8'd16;
      2'd2:    trig_of = 8'd56;
      default: trig_of = 8'd60;
    endcase
  endfunction
endpackage

// File: rtl/fcr_regs.sv
module fcr_regs
  import uart_fcr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] wdata_i,
  input  logic              ext_en_i,
  output logic              fifo_en_o,
  output logic              wake_en_o,
  output trig_sel_t         sel_o,
  output logic              rx_clr_o,
  output logic              tx_clr_o
);
  logic      en_q, wake_q;
  trig_sel_t sel_q;
  logic      arm;

  assign arm = we_i & wdata_i[EN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      wake_q <= 1'b0;
      sel_q  <= '0;
    end else if (we_i) begin
      en_q <= wdata_i[EN_BIT];
      if (wdata_i[EN_BIT]) begin
        if (ext_en_i) begin
          wake_q <= wdata_i[WAKE_BIT];
          sel_q  <= wdata_i[TXSEL_LO +: 2];
        end else begin
          sel_q  <= wdata_i[RXSEL_LO +: 2];
        end
      end
    end
  end

  // reset bits act as one-cycle strobes; nothing is stored
  assign rx_clr_o  = arm & wdata_i[RXCLR_BIT];
  assign tx_clr_o  = arm & wdata_i[TXCLR_BIT];
  assign fifo_en_o = en_q;
  assign wake_en_o = wake_q;
  assign sel_o     = sel_q;
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LVL_W-1:0]  level_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_q, rd_q;
  logic [LVL_W-1:0]  lvl_q;
  logic              full, empty, push_ok, pop_ok;

  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign push_ok = en_i & push_i & ~full;
  assign pop_ok  = en_i & pop_i & ~empty;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    nxt = (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (clr_i) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q);
      if (pop_ok)  rd_q <= nxt(rd_q);
      case ({push_ok, pop_ok})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok && !clr_i) mem_q[wr_q] <= data_i;
  end

  assign data_o  = mem_q[rd_q];
  assign level_o = lvl_q;
endmodule

// File: rtl/tx_trig_irq.sv
module tx_trig_irq #(
  parameter int unsigned LVL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [LVL_W-1:0] trig_i,
  output logic             irq_o
);
  logic [LVL_W-1:0] prev_q;
  logic             irq_q, fell_below, drained;

  assign fell_below = (prev_q >= trig_i) && (level_i < trig_i);
  assign drained    = (prev_q != '0) && (level_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      irq_q  <= 1'b0;
    end else if (clr_i) begin
      prev_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      prev_q <= level_i;
      if (fell_below || drained) irq_q <= 1'b1;
      else if (level_i >= trig_i) irq_q <= 1'b0;
    end
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/uart_fifo_ctrl.sv
module uart_fifo_ctrl
  import uart_fcr_pkg::*;
#(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  input  logic              ext_en_i,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_pop_i,
  output logic [DATA_W-1:0] tx_data_o,
  output logic [LVL_W-1:0]  tx_level_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic [LVL_W-1:0]  rx_level_o,
  output logic              fifo_en_o,
  output logic              wake_en_o,
  output logic [LVL_W-1:0]  trig_level_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              rx_overrun_o
);
  logic      en, rx_clr, tx_clr, tx_irq_raw, ovr_q;
  trig_sel_t sel;
  logic [LVL_W-1:0] trig;

  fcr_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctrl_we_i),
    .wdata_i   (ctrl_wdata_i),
    .ext_en_i  (ext_en_i),
    .fifo_en_o (en),
    .wake_en_o (wake_en_o),
    .sel_o     (sel),
    .rx_clr_o  (rx_clr),
    .tx_clr_o  (tx_clr)
  );

  assign trig = LVL_W'(trig_of(sel));

  byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .clr_i   (tx_clr),
    .push_i  (tx_push_i),
    .data_i  (tx_data_i),
    .pop_i   (tx_pop_i),
    .data_o  (tx_data_o),
    .level_o (tx_level_o)
  );

  byte_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en),
    .clr_i   (rx_clr),
    .push_i  (rx_push_i),
    .data_i  (rx_data_i),
    .pop_i   (rx_pop_i),
    .data_o  (rx_data_o),
    .level_o (rx_level_o)
  );

  tx_trig_irq #(.LVL_W(LVL_W)) u_tx_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (tx_clr),
    .level_i (tx_level_o),
    .trig_i  (trig),
    .irq_o   (tx_irq_raw)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                            ovr_q <= 1'b0;
    else if (rx_clr)                                        ovr_q <= 1'b0;
    else if (en && rx_push_i && rx_level_o == LVL_W'(DEPTH)) ovr_q <= 1'b1;
  end

  assign fifo_en_o    = en;
  assign trig_level_o = trig;
  assign rx_irq_o     = en && (rx_level_o >= trig);
  assign tx_irq_o     = en && tx_irq_raw;
  assign rx_overrun_o = ovr_q;
endmodule

// File: rtl/uart_fifo_ctrl_chk.sv
module uart_fifo_ctrl_chk #(
  parameter int unsigned DEPTH  = 128,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned LVL_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_we_i,
  input logic [7:0]        ctrl_wdata_i,
  input logic              ext_en_i,
  input logic [LVL_W-1:0]  tx_level_o,
  input logic [LVL_W-1:0]  rx_level_o,
  input logic              fifo_en_o,
  input logic              wake_en_o,
  input logic [LVL_W-1:0]  trig_level_o,
  input logic              tx_irq_o,
  input logic              rx_irq_o,
  input logic              rx_overrun_o
);
  // R2
  disable_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ctrl_wdata_i[0]) |=> (!fifo_en_o && $stable(trig_level_o) && $stable(wake_en_o)));
  // R3
  tx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[0] && ctrl_wdata_i[2]) |=> (tx_level_o == '0 && !tx_irq_o));
  // R3
  rx_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_wdata_i[0] && ctrl_wdata_i[1]) |=> (rx_level_o == '0 && !rx_overrun_o));
  // R4
  wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && !ext_en_i) |=> $stable(wake_en_o));
  // R6
  rx_irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> (rx_level_o >= trig_level_o));
  // R7
  tx_irq_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_irq_o) |-> ($past(tx_level_o) < $past(trig_level_o)));
  // R9
  level_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_level_o <= LVL_W'(DEPTH)) && (rx_level_o <= LVL_W'(DEPTH)));
  // R10
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_overrun_o && !(ctrl_we_i && ctrl_wdata_i[0] && ctrl_wdata_i[1])) |=> rx_overrun_o);
  // R11
  disabled_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_o |-> (!tx_irq_o && !rx_irq_o));
endmodule

bind uart_fifo_ctrl uart_fifo_ctrl_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctrl_we_i    (ctrl_we_i),
  .ctrl_wdata_i (ctrl_wdata_i),
  .ext_en_i     (ext_en_i),
  .tx_level_o   (tx_level_o),
  .rx_level_o   (rx_level_o),
  .fifo_en_o    (fifo_en_o),
  .wake_en_o    (wake_en_o),
  .trig_level_o (trig_level_o),
  .tx_irq_o     (tx_irq_o),
  .rx_irq_o     (rx_irq_o),
  .rx_overrun_o (rx_overrun_o)
);

// File: tb/uart_fifo_ctrl_tb.sv
module uart_fifo_ctrl_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ctrl_we_i = 1'b0;
  logic [7:0] ctrl_wdata_i = '0;
  logic       ext_en_i = 1'b0;
  logic       tx_push_i = 1'b0, tx_pop_i = 1'b0;
  logic [7:0] tx_data_i = '0;
  logic       rx_push_i = 1'b0, rx_pop_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic [7:0] tx_data_o, rx_data_o, tx_level_o, rx_level_o, trig_level_o;
  logic       fifo_en_o, wake_en_o, tx_irq_o, rx_irq_o, rx_overrun_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  uart_fifo_ctrl u_dut (.*);

  // {ext, wdata, exp_en, exp_trig, exp_wake}
  localparam logic [18:0] VECS [0:8] = '{
    {1'b0, 8'h01, 1'b1, 8'd8,  1'b0},
    {1'b0, 8'hC1, 1'b1, 8'd60, 1'b0},
    {1'b1, 8'h19, 1'b1, 8'd16, 1'b1},
    {1'b0, 8'h41, 1'b1, 8'd16, 1'b1},
    {1'b1, 8'h81, 1'b1, 8'd8,  1'b0},
    {1'b1, 8'hF8, 1'b0, 8'd8,  1'b0},
    {1'b1, 8'hB9, 1'b1, 8'd60, 1'b1},
    {1'b0, 8'h81, 1'b1, 8'd56, 1'b1},
    {1'b0, 8'h01, 1'b1, 8'd8,  1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic ext, input logic [7:0] d);
    ctrl_we_i = 1'b1; ctrl_wdata_i = d; ext_en_i = ext;
    @(negedge clk_i);
    ctrl_we_i = 1'b0; ext_en_i = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] d);
    rx_push_i = 1'b1; rx_data_i = d;
    @(negedge clk_i);
    rx_push_i = 1'b0;
  endtask

  task automatic pop_rx();
    rx_pop_i = 1'b1;
    @(negedge clk_i);
    rx_pop_i = 1'b0;
  endtask

  task automatic push_tx(input logic [7:0] d);
    tx_push_i = 1'b1; tx_data_i = d;
    @(negedge clk_i);
    tx_push_i = 1'b0;
  endtask

  task automatic pop_tx();
    tx_pop_i = 1'b1;
    @(negedge clk_i);
    tx_pop_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1
    chk("R1 en", fifo_en_o, 0);
    chk("R1 wake", wake_en_o, 0);
    chk("R1 trig", trig_level_o, 8);
    chk("R1 levels", tx_level_o + rx_level_o, 0);
    chk("R1 irqs", tx_irq_o + rx_irq_o, 0);
    chk("R1 overrun", rx_overrun_o, 0);

    // R5 R4 R2 table walk
    for (int i = 0; i < 9; i++) begin
      wr(VECS[i][18], VECS[i][17:10]);
      chk("R2 en", fifo_en_o, int'(VECS[i][9]));
      chk("R5 trig", trig_level_o, int'(VECS[i][8:1]));
      chk("R4 wake", wake_en_o, int'(VECS[i][0]));
    end

    // R6 receive trigger at 8
    for (int i = 0; i < 7; i++) push_rx(8'(i * 3 + 1));
    chk("R6 lvl7", rx_level_o, 7);
    chk("R6 irq below", rx_irq_o, 0);
    push_rx(8'd22);
    chk("R6 irq at", rx_irq_o, 1);
    chk("R9 head", rx_data_o, 1);
    pop_rx();
    chk("R6 irq drop", rx_irq_o, 0);
    for (int i = 1; i < 8; i++) begin
      chk("R9 order", rx_data_o, i * 3 + 1);
      pop_rx();
    end
    chk("R9 drained", rx_level_o, 0);
    pop_rx();
    chk("R9 pop empty", rx_level_o, 0);
    push_rx(8'd5);
    chk("R9 head after empty pop", rx_data_o, 5);

    // R9 R10 capacity and overrun
    for (int i = 0; i < 127; i++) push_rx(8'(i + 100));
    chk("R9 full", rx_level_o, 128);
    chk("R10 no ovr yet", rx_overrun_o, 0);
    push_rx(8'hEE);
    chk("R9 full push", rx_level_o, 128);
    chk("R10 ovr set", rx_overrun_o, 1);
    chk("R9 head kept", rx_data_o, 5);
    @(negedge clk_i);
    chk("R10 ovr sticky", rx_overrun_o, 1);

    // R3 per-direction reset
    for (int i = 0; i < 3; i++) push_tx(8'(8'hA0 + i));
    wr(1'b0, 8'h03);
    chk("R3 rx lvl", rx_level_o, 0);
    chk("R3 ovr clr", rx_overrun_o, 0);
    chk("R3 rx irq", rx_irq_o, 0);
    chk("R3 tx kept", tx_level_o, 3);
    wr(1'b0, 8'h04);
    chk("R2 no clr without en", tx_level_o, 3);
    chk("R2 disabled", fifo_en_o, 0);
    wr(1'b0, 8'h01);
    chk("R9 tx head", tx_data_o, 8'hA0);

    // R8 empty without reaching trigger
    chk("R8 irq idle", tx_irq_o, 0);
    for (int i = 0; i < 3; i++) pop_tx();
    chk("R8 lvl0", tx_level_o, 0);
    chk("R8 not yet", tx_irq_o, 0);
    @(negedge clk_i);
    chk("R8 irq empty", tx_irq_o, 1);

    // R7 threshold crossing
    for (int i = 0; i < 5; i++) push_tx(8'(i));
    chk("R7 held below", tx_irq_o, 1);
    for (int i = 0; i < 3; i++) push_tx(8'(i));
    chk("R7 lvl8", tx_level_o, 8);
    chk("R7 clr pending", tx_irq_o, 1);
    @(negedge clk_i);
    chk("R7 cleared", tx_irq_o, 0);
    pop_tx();
    chk("R7 set pending", tx_irq_o, 0);
    @(negedge clk_i);
    chk("R7 set", tx_irq_o, 1);

    wr(1'b0, 8'h05);
    chk("R3 tx lvl", tx_level_o, 0);
    chk("R3 tx irq", tx_irq_o, 0);
    @(negedge clk_i);
    chk("R3 tx irq stays", tx_irq_o, 0);

    // R11 disabled
    for (int i = 0; i < 8; i++) push_rx(8'(i));
    chk("R6 irq", rx_irq_o, 1);
    wr(1'b0, 8'h00);
    chk("R11 irq masked", rx_irq_o, 0);
    push_rx(8'h33);
    chk("R11 push ignored", rx_level_o, 8);
    pop_rx();
    chk("R11 pop ignored", rx_level_o, 8);
    push_tx(8'h44);
    chk("R11 tx push ignored", tx_level_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule